// File: doc/BRIEF.md
# Self-Timed Life Cell

This block is a single cell of a Game of Life grid in which there is no shared generation strobe. The cell keeps a one-bit alive/dead value and a generation number. Each generation opens by taking a copy of the stored value and offering it to the eight surrounding cells. The offers go out one port at a time, walking round the cell clockwise from the cell above. Meanwhile a one-place slot on each incoming port catches the neighbour's token for the same generation. A token that arrives early is parked there, so a faster neighbour does not stall.

Once all eight offers have been taken and all eight slots are full, the cell commits. It combines the parked values with its own, stores the result, empties the slots and opens the next generation. Each neighbour pair therefore synchronizes on its own. Two adjacent cells can be one generation apart, but never two. A port on the edge of the grid is wired to a source that always offers a dead token, and to a sink that is always ready.

Top module: `lsca_cell`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after it is released, every outgoing valid and every incoming ready is low. After that the stored state equals parameter INIT_ALIVE, the generation count is 0, all incoming ready bits are high, and only outgoing port 0 is valid, carrying INIT_ALIVE.
- R2: Port indices run clockwise from the cell above: 0 above, 1 above-right, 2 right, 3 below-right, 4 below, 5 below-left, 6 left, 7 above-left. At most one outgoing valid is high at a time. It stays high until its ready is seen. On the cycle after port k (k<7) is accepted, port k+1 is offered. After port 7 is accepted, no port is offered until the next commit.
- R3: Outgoing data on every port equals the state captured when the current generation opened. It does not change while a send is pending.
- R4: Incoming ready for port k is high exactly when that port's slot is empty. A token is captured on an edge where valid and ready are both high. It is kept until the next commit.
- R5: The cell commits on the first clock edge at which all eight slots are full and port 7 has already been accepted. The state and generation outputs change on that edge.
- R6: On commit, let C be the number of live cells among the cell and its eight parked neighbour values. The new state is 1 when C is 3, or when C is 4 and the old state is 1. Otherwise the new state is 0.
- R7: The generation cannot advance unless every neighbour has delivered a token since the previous commit. While one neighbour withholds its token, the generation count rises by at most one.
- R8: Each commit adds exactly one to the GEN_W-bit generation count, wrapping modulo 2^GEN_W.
- R9: On the commit edge all slots empty, and sending restarts at port 0 with the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronized inside |
| tx_valid_o | output | 8 | Outgoing token offered, one bit per neighbour port |
| tx_data_o | output | 8 | Outgoing token value per port |
| tx_ready_i | input | 8 | Neighbour accepts the outgoing token |
| rx_valid_i | input | 8 | Incoming token present, per port |
| rx_data_i | input | 8 | Incoming token value per port |
| rx_ready_o | output | 8 | Slot for that port is empty |
| state_o | output | 1 | Stored cell state |
| gen_o | output | GEN_W | Generation count (debug) |

## Verification
A stuck or wrongly cleared slot flag shows up on rx_ready_o on the very next cycle. It also shows up as a commit that comes too early or never comes, seen on gen_o. A wrong send index shows on tx_valid_o as a skipped or repeated port one cycle after a handshake. A wrong stored state or a wrong neighbour count shows on state_o on the commit edge. It shows again on tx_data_o for the whole of the next generation. A reference model runs alongside the cell and predicts every output on every cycle, so any of these faults is reported within one cycle of the edge that caused it.

// File: rtl/lsca_pkg.sv
package lsca_pkg;
  localparam int unsigned NBR_CNT   = 8;
  localparam int unsigned NBR_IDX_W = $clog2(NBR_CNT);
  localparam int unsigned LIVE_W    = $clog2(NBR_CNT + 2);

  typedef enum logic [NBR_IDX_W-1:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } nbr_dir_e;
endpackage

// File: rtl/lsca_rx_slot.sv
module lsca_rx_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic data_i,
  output logic ready_o,
  input  logic drain_i,
  output logic full_o,
  output logic data_o
);
  logic full_q, full_d;
  logic data_q, data_d;
  logic load;

  assign ready_o = rst_ni & ~full_q;
  assign load    = valid_i & ready_o;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (drain_i) begin
      full_d = 1'b0;
    end else if (load) begin
      full_d = 1'b1;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/lsca_tx_seq.sv
module lsca_tx_seq
  import lsca_pkg::*;
#(
  parameter bit INIT_BIT = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               bit_i,
  input  logic [NBR_CNT-1:0] ready_i,
  output logic [NBR_CNT-1:0] valid_o,
  output logic [NBR_CNT-1:0] data_o,
  output logic               done_o
);
  localparam logic [NBR_IDX_W-1:0] LAST_IDX = NBR_IDX_W'(NBR_CNT - 1);

  logic                 busy_q, busy_d;
  logic [NBR_IDX_W-1:0] idx_q, idx_d;
  logic                 bit_q, bit_d;
  logic                 fire;

  assign fire = busy_q & ready_i[idx_q];

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    bit_d  = bit_q;
    if (restart_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      bit_d  = bit_i;
    end else if (fire) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
      end else begin
        idx_d = NBR_IDX_W'(idx_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      bit_q  <= INIT_BIT;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
    end
  end

  for (genvar k = 0; k < NBR_CNT; k++) begin : g_port
    assign valid_o[k] = rst_ni & busy_q & (idx_q == NBR_IDX_W'(k));
    assign data_o[k]  = bit_q;
  end

  assign done_o = ~busy_q;
endmodule

// File: rtl/lsca_rule.sv
module lsca_rule
  import lsca_pkg::*;
(
  input  logic               self_i,
  input  logic [NBR_CNT-1:0] nbr_i,
  output logic               next_o
);
  logic [LIVE_W-1:0] live;

  always_comb begin
    live = LIVE_W'(self_i);
    for (int k = 0; k < NBR_CNT; k++) begin
      live = live + LIVE_W'(nbr_i[k]);
    end
  end

  assign next_o = (live == LIVE_W'(3)) | ((live == LIVE_W'(4)) & self_i);
endmodule

// File: rtl/lsca_cell.sv
module lsca_cell
  import lsca_pkg::*;
#(
  parameter bit          INIT_ALIVE = 1'b0,
  parameter int unsigned GEN_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [NBR_CNT-1:0] tx_valid_o,
  output logic [NBR_CNT-1:0] tx_data_o,
  input  logic [NBR_CNT-1:0] tx_ready_i,
  input  logic [NBR_CNT-1:0] rx_valid_i,
  input  logic [NBR_CNT-1:0] rx_data_i,
  output logic [NBR_CNT-1:0] rx_ready_o,
  output logic               state_o,
  output logic [GEN_W-1:0]   gen_o
);
  // two-stage release of the asynchronous reset
  logic [1:0] rst_sync_q;
  logic       run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign run = rst_sync_q[1];

  logic [NBR_CNT-1:0] slot_full;
  logic [NBR_CNT-1:0] slot_data;
  logic               tx_done;
  logic               commit;
  logic               next_state;

  for (genvar k = 0; k < NBR_CNT; k++) begin : g_slot
    lsca_rx_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (run),
      .valid_i (rx_valid_i[k]),
      .data_i  (rx_data_i[k]),
      .ready_o (rx_ready_o[k]),
      .drain_i (commit),
      .full_o  (slot_full[k]),
      .data_o  (slot_data[k])
    );
  end

  assign commit = tx_done & (&slot_full);

  lsca_rule u_rule (
    .self_i (state_q),
    .nbr_i  (slot_data),
    .next_o (next_state)
  );

  lsca_tx_seq #(
    .INIT_BIT (INIT_ALIVE)
  ) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (run),
    .restart_i (commit),
    .bit_i     (next_state),
    .ready_i   (tx_ready_i),
    .valid_o   (tx_valid_o),
    .data_o    (tx_data_o),
    .done_o    (tx_done)
  );

  logic             state_q, state_d;
  logic [GEN_W-1:0] gen_q, gen_d;

  always_comb begin
    state_d = state_q;
    gen_d   = gen_q;
    if (commit) begin
      state_d = next_state;
      gen_d   = GEN_W'(gen_q + 1'b1);
    end
  end

  always_ff @(posedge clk_i or negedge run) begin
    if (!run) begin
      state_q <= INIT_ALIVE;
      gen_q   <= '0;
    end else begin
      state_q <= state_d;
      gen_q   <= gen_d;
    end
  end

  assign state_o = state_q;
  assign gen_o   = gen_q;
endmodule

// File: rtl/lsca_cell_chk.sv
module lsca_cell_chk
  import lsca_pkg::*;
#(
  parameter int unsigned GEN_W = 8
) (
  input logic               clk_i,
  input logic               run_i,
  input logic [NBR_CNT-1:0] tx_valid_i,
  input logic [NBR_CNT-1:0] tx_data_i,
  input logic [NBR_CNT-1:0] tx_ready_i,
  input logic [NBR_CNT-1:0] rx_valid_i,
  input logic [NBR_CNT-1:0] rx_ready_i,
  input logic [GEN_W-1:0]   gen_i
);
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!run_i)
    $onehot0(tx_valid_i));

  // R2 and R3: a pending offer keeps its port and its value
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!run_i)
    (|(tx_valid_i & ~tx_ready_i)) |=>
      (tx_valid_i == $past(tx_valid_i)) && (tx_data_i == $past(tx_data_i)));

  for (genvar k = 0; k < NBR_CNT; k++) begin : g_port
    if (k < NBR_CNT - 1) begin : g_order
      a_r2_order: assert property (@(posedge clk_i) disable iff (!run_i)
        (tx_valid_i[k] && tx_ready_i[k]) |=> tx_valid_i[k+1]);
    end
    a_r4_fill: assert property (@(posedge clk_i) disable iff (!run_i)
      (rx_valid_i[k] && rx_ready_i[k]) |=> !rx_ready_i[k]);
  end

  a_r8_step: assert property (@(posedge clk_i) disable iff (!run_i)
    (gen_i == $past(gen_i)) || (gen_i == GEN_W'($past(gen_i) + 1'b1)));

  a_r7_gate: assert property (@(posedge clk_i) disable iff (!run_i)
    (gen_i != $past(gen_i)) |->
      ($past(rx_ready_i) == '0) && ($past(tx_valid_i) == '0));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!run_i)
    (gen_i != $past(gen_i)) |->
      (tx_valid_i == NBR_CNT'(1)) && (&rx_ready_i));
endmodule

bind lsca_cell lsca_cell_chk #(.GEN_W(GEN_W)) u_chk (
  .clk_i      (clk_i),
  .run_i      (run),
  .tx_valid_i (tx_valid_o),
  .tx_data_i  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_i (rx_ready_o),
  .gen_i      (gen_o)
);

// File: tb/lsca_cell_test.sv
module lsca_cell_test;
  import lsca_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int GW         = 4;
  localparam bit INIT       = 1'b1;
  localparam int N          = NBR_CNT;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  tx_valid, tx_data, tx_ready;
  logic [N-1:0]  rx_valid, rx_data, rx_ready;
  logic          state;
  logic [GW-1:0] gen;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsca_cell #(.INIT_ALIVE(INIT), .GEN_W(GW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .state_o(state), .gen_o(gen)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  logic [1:0] m_sync;
  bit  m_busy, m_bit, m_state, old_run, commit, tx_fire, nxt;
  int  m_idx, m_gen, live;
  bit  m_full [N];
  bit  m_data [N];
  bit  pend   [N];
  bit  rx_fire[N];
  int  p_valid, p_ready, density;
  bit  stall5, cmp_en;

  initial begin
    for (int k = 0; k < N; k++) pend[k] = ($urandom_range(99) < 50);
  end

  always @(posedge clk) begin
    old_run = m_sync[1];
    if (!rst_n) m_sync = 2'b00;
    else        m_sync = {m_sync[0], 1'b1};
    if (!rst_n || !old_run) begin
      m_busy = 1'b1; m_idx = 0; m_bit = INIT; m_state = INIT; m_gen = 0;
      for (int k = 0; k < N; k++) begin m_full[k] = 1'b0; m_data[k] = 1'b0; end
    end else begin
      commit = !m_busy;
      for (int k = 0; k < N; k++) if (!m_full[k]) commit = 1'b0;
      tx_fire = m_busy && tx_ready[m_idx];
      for (int k = 0; k < N; k++) rx_fire[k] = rx_valid[k] && !m_full[k];
      if (commit) begin
        live = m_state;
        for (int k = 0; k < N; k++) live += m_data[k];
        nxt = (live == 3) || (live == 4 && m_state);
        m_state = nxt; m_bit = nxt;
        m_gen = (m_gen + 1) % (1 << GW);
        m_busy = 1'b1; m_idx = 0;
        for (int k = 0; k < N; k++) m_full[k] = 1'b0;
      end else begin
        if (tx_fire) begin
          if (m_idx == N - 1) m_busy = 1'b0;
          else m_idx++;
        end
        for (int k = 0; k < N; k++) begin
          if (rx_fire[k]) begin
            m_full[k] = 1'b1;
            m_data[k] = pend[k];
            pend[k]   = ($urandom_range(99) < density);
          end
        end
      end
    end
  end

  // compare, then drive the neighbours
  always @(negedge clk) begin
    int ev, er, ed;
    if (cmp_en) begin
      ev = (m_sync[1] && m_busy) ? (1 << m_idx) : 0;
      er = 0;
      for (int k = 0; k < N; k++) if (m_sync[1] && !m_full[k]) er |= (1 << k);
      ed = m_bit ? ((1 << N) - 1) : 0;
      chk("R2,R9", "tx_valid", int'(tx_valid), ev);
      chk("R3", "tx_data", int'(tx_data), ed);
      chk("R4", "rx_ready", int'(rx_ready), er);
      chk("R6", "state", int'(state), int'(m_state));
      chk("R5,R8", "gen", int'(gen), m_gen);
    end
    for (int k = 0; k < N; k++) begin
      rx_valid[k] <= ($urandom_range(99) < p_valid) && !(stall5 && k == 5);
      rx_data[k]  <= pend[k];
      tx_ready[k] <= ($urandom_range(99) < p_ready);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int g0, dg;
    rst_n = 1'b0; p_valid = 0; p_ready = 0; density = 50; stall5 = 1'b0;
    cmp_en = 1'b0;
    rx_valid = '0; rx_data = '0; tx_ready = '0;
    m_sync = 2'b00;
    repeat (3) @(posedge clk);
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R1", "ready during reset", int'(rx_ready), 0);
    chk("R1", "valid during reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset gen", int'(gen), 0);
    chk("R1", "reset state", int'(state), int'(INIT));
    chk("R1", "reset tx_valid", int'(tx_valid), 1);
    chk("R1", "reset tx_data", int'(tx_data), 255);
    chk("R1", "reset rx_ready", int'(rx_ready), 255);

    p_valid = 80; p_ready = 80; density = 50;
    repeat (1500) @(posedge clk);

    // R6: a full neighbourhood dies
    density = 100;
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk("R6", "crowded state", int'(state), 0);

    // R6: an empty neighbourhood stays dead
    density = 0;
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R6", "empty state", int'(state), 0);

    density = 38;
    repeat (1500) @(posedge clk);

    // R7: a silent neighbour holds the cell within one generation
    stall5 = 1'b1; p_valid = 100;
    repeat (20) @(posedge clk);
    @(negedge clk);
    g0 = int'(gen);
    repeat (80) @(posedge clk);
    @(negedge clk);
    dg = (int'(gen) - g0 + (1 << GW)) % (1 << GW);
    chk("R7", "gen advance while stalled", int'(dg <= 1), 1);
    chk("R7", "stalled slot empty", int'(rx_ready[5]), 1);
    stall5 = 1'b0;

    p_valid = 20; p_ready = 20; density = 45;
    repeat (1500) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule